// File: doc/BRIEF.md
# Low-Side Channel Fault Controller

This block holds the digital protection and diagnostic state for one channel of a low-side valve driver. It takes the host's enable and channel command pins, plus four comparator flags from the analog front end: output voltage low in the off state, load current below the open-load level, load current above the overload level, and overtemperature. From these it drives the power-stage gate enable, a current-limit request to the analog regulator, and an active-low diagnostic bit. The host reads the fault class by combining the diagnostic level with the enable and command levels it drives.

All six inputs are asynchronous and pass through a two-flop synchronizer before use. An overload is first held under current limit for a programmable number of clock cycles. After that the channel is latched off. Overtemperature switches the gate off for as long as the flag is present. It also leaves a diagnostic latch set until the command goes low. If the command stays high through an overtemperature event, the overload timer also runs. Once that timer expires, the channel stays off even after the temperature recovers. An open load in the on state is reported after its own delay.

Top module: `lsd_fault_ctrl`

## Requirements
- R1: With the synchronized enable low, `gate_on` is 0 and, one cycle later, `diag_n` is 0, whatever the command level.
- R2: With enable high and no fault, `gate_on` follows the synchronized command and `diag_n` is 1 for both command levels.
- R3: While the gate is on and the over-current flag is present, `ilim_req` is 1. `ilim_req` is never 1 while `gate_on` is 0.
- R4: If the over-current flag holds for OL_DLY consecutive synchronized cycles with the gate commanded on, the overload latch sets. `gate_on` then drops at the next edge and stays 0 while the command stays high, and `diag_n` goes to 0. If the flag lapses before expiry, the count restarts from zero.
- R5: The synchronized overtemperature flag forces `gate_on` to 0 at once and pulls `diag_n` low. The diagnostic latch it sets keeps `diag_n` at 0 after the flag clears, as long as the command stays high. If the flag clears before OL_DLY cycles, the gate turns on again.
- R6: The overload and overtemperature latches clear one cycle after the synchronized command is low.
- R7: When overtemperature persists for OL_DLY cycles with the command high, the overload latch sets, so `gate_on` stays 0 after the flag clears.
- R8: With enable high and the gate off for at least one cycle, a low output-voltage flag gives `diag_n` 0. The same flag has no effect while the gate is on.
- R9: With the gate on and stable, an under-current flag held for OPN_DLY cycles drives `diag_n` to 0. A shorter flag has no effect. The under-current flag is ignored while the gate is off.
- R10: During and right after reset, `gate_on`, `ilim_req` and `diag_n` are 0, and all latches are clear.
- R11: A pin change reaches `gate_on` after exactly two clock edges. The synchronizer resets to 0, so a pin that has never been driven high reads as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_pin | input | 1 | Channel enable pin, asynchronous |
| in_pin | input | 1 | Channel on/off command pin, asynchronous |
| vout_low | input | 1 | Output voltage below off-state threshold |
| iload_low | input | 1 | Load current below open-load threshold |
| iload_high | input | 1 | Load current above overload threshold |
| overtemp | input | 1 | Junction overtemperature flag |
| gate_on | output | 1 | Power-stage gate enable |
| ilim_req | output | 1 | Current-limit request to the analog stage |
| diag_n | output | 1 | Diagnostic, low on fault or when disabled |

## Verification
The bench builds the block with OL_DLY = 8 and OPN_DLY = 5. These values are far below the defaults, so both timers can be stepped edge by edge. The checks land on the last cycle before expiry and on the first cycle after it. They also cover over-current bursts one cycle short of the limit, which must restart the count. A short overtemperature burst and one longer than OL_DLY are then distinguishable at the gate once the flag clears.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef struct packed {
    logic en;
    logic cmd;
    logic vlow;
    logic ilow;
    logic ihigh;
    logic otemp;
  } lsd_flags_t;
  localparam int unsigned FLAGS_W = $bits(lsd_flags_t);
endpackage

// File: rtl/lsd_sync.sv
module lsd_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lsd_dly_timer.sv
module lsd_dly_timer #(
  parameter int unsigned DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic fire
);
  localparam int unsigned CW = (DLY < 2) ? 1 : $clog2(DLY);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);
  logic [CW-1:0] cnt;

  // fire marks the DLY-th consecutive cycle of run
  assign fire = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!fire)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lsd_fault_ctrl.sv
module lsd_fault_ctrl #(
  parameter int unsigned OL_DLY  = 2000,
  parameter int unsigned OPN_DLY = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_pin,
  input  logic in_pin,
  input  logic vout_low,
  input  logic iload_low,
  input  logic iload_high,
  input  logic overtemp,
  output logic gate_on,
  output logic ilim_req,
  output logic diag_n
);
  import lsd_pkg::*;

  lsd_flags_t raw, sf;
  logic s_en, s_in, s_otemp;
  logic ol_q, ot_q, ow_q, on_q, off_q;
  logic cmd_on, ol_run, ol_fire, opn_run, opn_fire, vlow_flt, diag_nx;

  assign raw = '{en: en_pin, cmd: in_pin, vlow: vout_low, ilow: iload_low,
                 ihigh: iload_high, otemp: overtemp};

  lsd_sync #(.W(FLAGS_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(sf)
  );

  assign s_en    = sf.en;
  assign s_in    = sf.cmd;
  assign s_otemp = sf.otemp;
  assign cmd_on  = s_en && s_in;

  // Overload delay: real over-current, or overdrop during thermal shutdown
  assign ol_run = cmd_on && !ol_q && (sf.ihigh || s_otemp);

  lsd_dly_timer #(.DLY(OL_DLY)) u_ol_tmr (
    .clk(clk), .rst_n(rst_n), .run(ol_run), .fire(ol_fire)
  );

  assign gate_on  = cmd_on && !ol_q && !s_otemp;
  assign ilim_req = gate_on && sf.ihigh;

  // Open-load delay only once the on state has settled
  assign opn_run = gate_on && on_q && sf.ilow;

  lsd_dly_timer #(.DLY(OPN_DLY)) u_opn_tmr (
    .clk(clk), .rst_n(rst_n), .run(opn_run), .fire(opn_fire)
  );

  assign vlow_flt = s_en && !gate_on && off_q && sf.vlow;
  assign diag_nx  = s_en && !ol_q && !ot_q && !s_otemp && !vlow_flt && !ow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ol_q   <= 1'b0;
      ot_q   <= 1'b0;
      ow_q   <= 1'b0;
      on_q   <= 1'b0;
      off_q  <= 1'b0;
      diag_n <= 1'b0;
    end else begin
      ol_q   <= s_in && (ol_q || ol_fire);
      ot_q   <= s_in && (ot_q || s_otemp);
      ow_q   <= opn_run && (ow_q || opn_fire);
      on_q   <= gate_on;
      off_q  <= !gate_on;
      diag_n <= diag_nx;
    end
  end
endmodule

// File: rtl/lsd_fault_chk.sv
module lsd_fault_chk (
  input logic clk,
  input logic rst_n,
  input logic s_en,
  input logic s_in,
  input logic s_otemp,
  input logic gate_on,
  input logic ilim_req,
  input logic diag_n,
  input logic ol_q,
  input logic ot_q
);
  AST_EN_LOW_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !s_en |-> !gate_on); // R1
  AST_EN_LOW_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
    !s_en |=> !diag_n); // R1
  AST_ILIM_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_req |-> gate_on); // R3
  AST_OL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ol_q && s_in |=> ol_q); // R4
  AST_OL_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ol_q |-> !gate_on); // R4
  AST_OT_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    s_otemp |-> !gate_on); // R5
  AST_OT_DIAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ot_q |=> !diag_n); // R5
  AST_IN_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !s_in |=> !ol_q && !ot_q); // R6
endmodule

bind lsd_fault_ctrl lsd_fault_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_en(s_en), .s_in(s_in), .s_otemp(s_otemp),
  .gate_on(gate_on), .ilim_req(ilim_req), .diag_n(diag_n),
  .ol_q(ol_q), .ot_q(ot_q)
);

// File: tb/lsd_fault_ctrl_bench.sv
module lsd_fault_ctrl_bench;
  localparam int unsigned OL  = 8;
  localparam int unsigned OPN = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 1'b0, in_pin = 1'b0, vout_low = 1'b0;
  logic iload_low = 1'b0, iload_high = 1'b0, overtemp = 1'b0;
  logic gate_on, ilim_req, diag_n;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  lsd_fault_ctrl #(.OL_DLY(OL), .OPN_DLY(OPN)) u_lsd_fault_ctrl (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .in_pin(in_pin),
    .vout_low(vout_low), .iload_low(iload_low), .iload_high(iload_high),
    .overtemp(overtemp), .gate_on(gate_on), .ilim_req(ilim_req), .diag_n(diag_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // n rising edges, then park on the falling edge
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_on();
    en_pin = 1; in_pin = 0; vout_low = 0; iload_low = 0; iload_high = 0; overtemp = 0;
    edges(4);
    in_pin = 1;
    edges(4);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 gate in reset", gate_on, 0);
    chk("R10 diag in reset", diag_n, 0);
    chk("R10 ilim in reset", ilim_req, 0);
    rst_n = 1;
    edges(3);
    chk("R11 undriven pins read low: gate", gate_on, 0);
    chk("R1 diag low with enable low", diag_n, 0);
  endtask

  task automatic t_enable();
    en_pin = 0; in_pin = 1;
    edges(4);
    chk("R1 gate off with EN low IN high", gate_on, 0);
    chk("R1 diag low with EN low IN high", diag_n, 0);
    en_pin = 1;
    edges(1);
    chk("R11 gate not yet after one edge", gate_on, 0);
    edges(1);
    chk("R11 gate on after two edges", gate_on, 1);
    edges(2);
    chk("R2 diag high when on", diag_n, 1);
    in_pin = 0;
    edges(4);
    chk("R2 gate off IN low", gate_on, 0);
    chk("R2 diag high when off", diag_n, 1);
  endtask

  task automatic t_overload();
    idle_on();
    iload_high = 1;
    edges(OL + 1);
    chk("R3 limit requested", ilim_req, 1);
    chk("R4 gate still on before expiry", gate_on, 1);
    edges(1);
    chk("R4 gate off after expiry", gate_on, 0);
    chk("R3 no limit with gate off", ilim_req, 0);
    iload_high = 0;
    edges(6);
    chk("R4 latched off", gate_on, 0);
    chk("R4 diag low", diag_n, 0);
    in_pin = 0;
    edges(4);
    chk("R6 diag recovers after IN low", diag_n, 1);
    in_pin = 1;
    edges(3);
    chk("R6 gate back on", gate_on, 1);
  endtask

  task automatic t_ol_restart();
    idle_on();
    for (int k = 0; k < 3; k++) begin
      iload_high = 1;
      edges(OL - 1);
      iload_high = 0;
      edges(2);
    end
    edges(3);
    chk("R4 short bursts restart count: gate", gate_on, 1);
    chk("R4 short bursts restart count: diag", diag_n, 1);
  endtask

  task automatic t_ot_short();
    idle_on();
    overtemp = 1;
    edges(2);
    chk("R5 gate off on overtemp", gate_on, 0);
    edges(1);
    overtemp = 0;
    edges(4);
    chk("R5 gate returns after short overtemp", gate_on, 1);
    chk("R5 diag latched low", diag_n, 0);
    in_pin = 0;
    edges(4);
    chk("R6 overtemp latch cleared", diag_n, 1);
  endtask

  task automatic t_ot_long();
    idle_on();
    overtemp = 1;
    edges(OL + 4);
    overtemp = 0;
    edges(5);
    chk("R7 overload latch holds gate off", gate_on, 0);
    chk("R7 diag low", diag_n, 0);
    in_pin = 0;
    edges(4);
    in_pin = 1;
    edges(4);
    chk("R6 gate on after release", gate_on, 1);
  endtask

  task automatic t_vlow();
    en_pin = 1; in_pin = 0;
    edges(4);
    vout_low = 1;
    edges(4);
    chk("R8 off-state low voltage reports", diag_n, 0);
    vout_low = 0;
    edges(4);
    chk("R8 diag recovers", diag_n, 1);
    in_pin = 1; vout_low = 1;
    edges(6);
    chk("R8 flag ignored while on", diag_n, 1);
    vout_low = 0;
  endtask

  task automatic t_openload();
    idle_on();
    iload_low = 1;
    edges(OPN + 2);
    chk("R9 diag high before open-load expiry", diag_n, 1);
    edges(1);
    chk("R9 diag low after open-load delay", diag_n, 0);
    iload_low = 0;
    edges(4);
    chk("R9 diag recovers", diag_n, 1);
    iload_low = 1;
    edges(OPN - 1);
    iload_low = 0;
    edges(4);
    chk("R9 short under-current ignored", diag_n, 1);
    in_pin = 0; iload_low = 1;
    edges(OPN + 6);
    chk("R9 under-current ignored while off", diag_n, 1);
    iload_low = 0;
  endtask

  initial begin
    t_reset();
    t_enable();
    t_overload();
    t_ol_restart();
    t_ot_short();
    t_ot_long();
    t_vlow();
    t_openload();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule